// File: doc/BRIEF.md
# Deferred Video Memory Data Port

This block sits between a processor's register bus and the memories of a tile-based picture generator. It provides a data window into a 14-bit video address space. A 15-bit current-address register selects the location, and the address is loaded with two byte writes. A read of the data window does not go to memory. It returns a byte that was fetched earlier into a read buffer. Each access then schedules its real memory operation a fixed number of pixel steps later. For a read, that operation refills the buffer. For a write, it commits a latched byte. Only when that deferred operation completes does the current address advance, by 1 or by 32.

A committed write is routed by its masked address. The palette area (0x3F00 and up) goes to a small palette RAM. Everything below goes to the video memory bus. Writes that commit while visible lines are being drawn are corrupted: the video memory receives the low address byte instead of the data. A reduced sprite attribute port sits alongside. Outside rendering it stores a byte and steps its address by one. During rendering it stores nothing and only advances the upper six address bits. Reads of the data window in the palette area bypass the buffer and return palette contents, optionally reduced to their luminance bits.

Top module: `vdata_port`

## Requirements
- R1: With `cpuSel` = 0 (data window), a cycle with `cpuRd` high returns the read-buffer byte on `cpuRdata` in that same cycle when the masked address is below 0x3F00. The buffer is refilled from `vmRdata` at the masked address: `vmRd` is high in the 5th pixel-step cycle after the read cycle. After reset the buffer holds 0x00.
- R2: A cycle with `cpuWr` high and `cpuSel` = 0 latches `cpuWdata`. The memory write strobe (`vmWe` or `palWe`) rises only in the 5th pixel-step cycle after the write cycle, and no memory changes before then.
- R3: Only address bits 13:0 reach the memories. `cpuSel` = 1 writes `cpuWdata[6:0]` into address bits 14:8, and `cpuSel` = 2 writes `cpuWdata` into bits 7:0. Bit 14 never affects routing or the bus address.
- R4: A commit whose masked address is 0x3F00 or above raises `palWe` with `palAddr` = address bits 4:0 and the latched byte. Any lower address raises `vmWe` at `vmAddr`. The two strobes are never high together.
- R5: A video memory commit while `renderOn` is high and `scanLine` < 240 stores address bits 7:0 instead of the latched byte. At `scanLine` >= 240, or with rendering off, the latched byte is stored.
- R6: The current address advances only in the cycle in which a deferred read or write completes: by 32 when `step32` is high, otherwise by 1. A CPU address-byte write in that same cycle takes priority over the advance.
- R7: `cpuSel` = 3 loads the attribute address. A `cpuSel` = 4 write with rendering off, or on a line that is neither below 240 nor 261, raises `attrWe` with `cpuWdata` and advances `attrAddr` by 1. With `renderOn` high on lines 0-239 or on line 261, no attribute write occurs, and `attrAddr` becomes (`attrAddr` + 4) AND 0xFC.
- R8: A data-window read at a masked address of 0x3F00 or above returns `palRdata` directly. When `gray` is high, the returned byte is `palRdata` AND 0x30.
- R9: A new data-window access of the same kind while its countdown is running restarts the countdown at 5. A write also replaces the latched byte, so only one operation results.
- R10: A read and a write that complete in the same cycle both use the same address. The buffer receives the contents from before the write, and the address advances once.
- R11: Countdowns advance only in cycles with `pixEn` high. Cycles with `pixEn` low delay completion one-for-one.
- R12: Reset clears the current address, the read buffer and the attribute address, and cancels both countdowns. `cpuRdata` is 0x00 except during a data-window read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Pixel-step enable for the countdowns |
| renderOn | input | 1 | Rendering enabled |
| scanLine | input | 9 | Current scanline number |
| step32 | input | 1 | Advance by 32 instead of 1 |
| gray | input | 1 | Luminance-only palette readback |
| cpuRd | input | 1 | CPU read strobe |
| cpuWr | input | 1 | CPU write strobe |
| cpuSel | input | 3 | Register select |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | CPU read data |
| vmAddr | output | 14 | Video memory address (current address, masked) |
| vmRd | output | 1 | Video memory read strobe (buffer refill) |
| vmWe | output | 1 | Video memory write strobe |
| vmWdata | output | 8 | Video memory write data |
| vmRdata | input | 8 | Video memory read data (combinational) |
| palAddr | output | 5 | Palette RAM address |
| palWe | output | 1 | Palette RAM write strobe |
| palWdata | output | 8 | Palette RAM write data |
| palRdata | input | 8 | Palette RAM read data (combinational) |
| attrAddr | output | 8 | Sprite attribute address |
| attrWe | output | 1 | Sprite attribute write strobe |
| attrWdata | output | 8 | Sprite attribute write data |

## Verification
The deferred refill of a read and the deferred commit of a write can complete in the same cycle. Both then use one address, and only one advance may follow. The bench provokes this by issuing a read and, in the next cycle, a write while `pixEn` is held low, so that both countdowns start from 5 in step. It judges the result by the cycle in which the two scoreboard entries appear, the single advance seen on `vmAddr`, and a later read that must return the byte from before the write. A second collision is tested the same way: an address-byte write lands in the completion cycle of a commit, and the bench checks that the loaded address wins over the advance.

// File: rtl/vdp_pkg.sv
package vdp_pkg;

  localparam logic [2:0] SEL_DATA      = 3'd0;
  localparam logic [2:0] SEL_ADDR_HI   = 3'd1;
  localparam logic [2:0] SEL_ADDR_LO   = 3'd2;
  localparam logic [2:0] SEL_ATTR_ADDR = 3'd3;
  localparam logic [2:0] SEL_ATTR_DATA = 3'd4;

  // strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic rdData;     // data-window read in progress this cycle
    logic latch;      // capture CPU byte into the write latch
    logic loadHi;     // load address upper bits
    logic loadLo;     // load address low byte
    logic fill;       // deferred read completes: refill buffer
    logic commit;     // deferred write completes
    logic mangle;     // commit during drawn lines stores address byte
    logic bump;       // advance current address
    logic attrLoad;   // load attribute address
    logic attrWrite;  // normal attribute store
    logic attrGlitch; // rendering-time attribute address bump
  } strobe_t;

endpackage

// File: rtl/vdp_countdown.sv
module vdp_countdown #(
  parameter int DLY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step,
  output logic fire
);
  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (start)                  cnt <= CW'(DLY);
    else if (step && cnt != '0)      cnt <= cnt - CW'(1);
  end

  // a restart in the expiring cycle cancels the old operation
  assign fire = step && !start && (cnt == CW'(1));
endmodule

// File: rtl/vdp_ctrl.sv
module vdp_ctrl import vdp_pkg::*; #(
  parameter int DLY       = 5,
  parameter int LINE_W    = 9,
  parameter int VIS_LINES = 240,
  parameter int PRE_LINE  = 261
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pixEn,
  input  logic              renderOn,
  input  logic [LINE_W-1:0] scanLine,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [2:0]        cpuSel,
  output strobe_t           st
);
  localparam logic [LINE_W-1:0] VIS_L = LINE_W'(VIS_LINES);
  localparam logic [LINE_W-1:0] PRE_L = LINE_W'(PRE_LINE);
  localparam int NCH = 2; // channel 0 = read refill, 1 = write commit

  logic [NCH-1:0] startV, fireV;
  logic dataSel, drawnLine, renderLine;

  assign dataSel   = (cpuSel == SEL_DATA);
  assign startV[0] = cpuRd && dataSel;
  assign startV[1] = cpuWr && dataSel;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    vdp_countdown #(.DLY(DLY)) u_cd (
      .clk  (clk),
      .rst_n(rst_n),
      .start(startV[ch]),
      .step (pixEn),
      .fire (fireV[ch])
    );
  end

  assign drawnLine  = renderOn && (scanLine < VIS_L);
  assign renderLine = drawnLine || (renderOn && scanLine == PRE_L);

  always_comb begin
    st            = '0;
    st.rdData     = startV[0];
    st.latch      = startV[1];
    st.loadHi     = cpuWr && cpuSel == SEL_ADDR_HI;
    st.loadLo     = cpuWr && cpuSel == SEL_ADDR_LO;
    st.fill       = fireV[0];
    st.commit     = fireV[1];
    st.mangle     = drawnLine;
    st.bump       = fireV[0] || fireV[1];
    st.attrLoad   = cpuWr && cpuSel == SEL_ATTR_ADDR;
    st.attrWrite  = cpuWr && cpuSel == SEL_ATTR_DATA && !renderLine;
    st.attrGlitch = cpuWr && cpuSel == SEL_ATTR_DATA && renderLine;
  end
endmodule

// File: rtl/vdp_dpath.sv
module vdp_dpath import vdp_pkg::*; #(
  parameter int                ADDR_W   = 14,
  parameter int                VREG_W   = 15,
  parameter logic [ADDR_W-1:0] PAL_BASE = 14'h3F00,
  parameter int                PAL_AW   = 5,
  parameter int                ATTR_AW  = 8,
  parameter int                STEP_BIG = 32,
  parameter logic [7:0]        GRAY_MSK = 8'h30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            st,
  input  logic               step32,
  input  logic               gray,
  input  logic [7:0]         cpuWdata,
  output logic [7:0]         cpuRdata,
  output logic [ADDR_W-1:0]  vmAddr,
  output logic               vmRd,
  output logic               vmWe,
  output logic [7:0]         vmWdata,
  input  logic [7:0]         vmRdata,
  output logic [PAL_AW-1:0]  palAddr,
  output logic               palWe,
  output logic [7:0]         palWdata,
  input  logic [7:0]         palRdata,
  output logic [ATTR_AW-1:0] attrAddr,
  output logic               attrWe,
  output logic [7:0]         attrWdata
);
  localparam int HI_W = VREG_W - 8;
  localparam logic [ATTR_AW-1:0] ATTR_HI_MSK = ~ATTR_AW'(3);

  logic [VREG_W-1:0]  vAddr, stepVal;
  logic [7:0]         readBuf, wrLatch;
  logic [ATTR_AW-1:0] attrReg;
  logic [ADDR_W-1:0]  busAddr;
  logic               isPal;

  assign stepVal = step32 ? VREG_W'(STEP_BIG) : VREG_W'(1);
  assign busAddr = vAddr[ADDR_W-1:0];
  assign isPal   = busAddr >= PAL_BASE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vAddr   <= '0;
      readBuf <= '0;
      wrLatch <= '0;
      attrReg <= '0;
    end else begin
      // CPU address loads win over the completion advance
      if (st.loadHi)    vAddr[VREG_W-1:8] <= cpuWdata[HI_W-1:0];
      else if (st.loadLo) vAddr[7:0] <= cpuWdata;
      else if (st.bump) vAddr <= vAddr + stepVal;

      if (st.latch) wrLatch <= cpuWdata;
      if (st.fill)  readBuf <= vmRdata;

      if (st.attrLoad)        attrReg <= cpuWdata[ATTR_AW-1:0];
      else if (st.attrWrite)  attrReg <= attrReg + ATTR_AW'(1);
      else if (st.attrGlitch) attrReg <= (attrReg + ATTR_AW'(4)) & ATTR_HI_MSK;
    end
  end

  assign vmAddr    = busAddr;
  assign vmRd      = st.fill;
  assign vmWe      = st.commit && !isPal;
  assign vmWdata   = st.mangle ? busAddr[7:0] : wrLatch;
  assign palAddr   = busAddr[PAL_AW-1:0];
  assign palWe     = st.commit && isPal;
  assign palWdata  = wrLatch;
  assign attrAddr  = attrReg;
  assign attrWe    = st.attrWrite;
  assign attrWdata = cpuWdata;

  always_comb begin
    if (!st.rdData)  cpuRdata = '0;
    else if (isPal)  cpuRdata = gray ? (palRdata & GRAY_MSK) : palRdata;
    else             cpuRdata = readBuf;
  end
endmodule

// File: rtl/vdata_port.sv
module vdata_port import vdp_pkg::*; #(
  parameter int DLY       = 5,
  parameter int LINE_W    = 9,
  parameter int VIS_LINES = 240,
  parameter int PRE_LINE  = 261,
  parameter int ADDR_W    = 14,
  parameter int VREG_W    = 15,
  parameter int PAL_AW    = 5,
  parameter int ATTR_AW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pixEn,
  input  logic               renderOn,
  input  logic [LINE_W-1:0]  scanLine,
  input  logic               step32,
  input  logic               gray,
  input  logic               cpuRd,
  input  logic               cpuWr,
  input  logic [2:0]         cpuSel,
  input  logic [7:0]         cpuWdata,
  output logic [7:0]         cpuRdata,
  output logic [ADDR_W-1:0]  vmAddr,
  output logic               vmRd,
  output logic               vmWe,
  output logic [7:0]         vmWdata,
  input  logic [7:0]         vmRdata,
  output logic [PAL_AW-1:0]  palAddr,
  output logic               palWe,
  output logic [7:0]         palWdata,
  input  logic [7:0]         palRdata,
  output logic [ATTR_AW-1:0] attrAddr,
  output logic               attrWe,
  output logic [7:0]         attrWdata
);
  strobe_t st;

  vdp_ctrl #(
    .DLY(DLY), .LINE_W(LINE_W), .VIS_LINES(VIS_LINES), .PRE_LINE(PRE_LINE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pixEn(pixEn), .renderOn(renderOn),
    .scanLine(scanLine), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuSel(cpuSel),
    .st(st)
  );

  vdp_dpath #(
    .ADDR_W(ADDR_W), .VREG_W(VREG_W), .PAL_AW(PAL_AW), .ATTR_AW(ATTR_AW)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .st(st), .step32(step32), .gray(gray),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .vmAddr(vmAddr), .vmRd(vmRd), .vmWe(vmWe), .vmWdata(vmWdata), .vmRdata(vmRdata),
    .palAddr(palAddr), .palWe(palWe), .palWdata(palWdata), .palRdata(palRdata),
    .attrAddr(attrAddr), .attrWe(attrWe), .attrWdata(attrWdata)
  );
endmodule

// File: rtl/vdp_port_chk.sv
module vdp_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        renderOn,
  input logic [8:0]  scanLine,
  input logic        step32,
  input logic        cpuRd,
  input logic        cpuWr,
  input logic [2:0]  cpuSel,
  input logic [13:0] vmAddr,
  input logic        vmRd,
  input logic        vmWe,
  input logic [7:0]  vmWdata,
  input logic        palWe,
  input logic [7:0]  attrAddr,
  input logic        attrWe
);
  logic glitchWr, addrWr;
  assign glitchWr = cpuWr && cpuSel == 3'd4 && renderOn &&
                    (scanLine < 9'd240 || scanLine == 9'd261);
  assign addrWr   = cpuWr && (cpuSel == 3'd1 || cpuSel == 3'd2);

  AST_RD_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuRd && cpuSel == 3'd0) |=> !vmRd);                                  // R1
  AST_WR_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuWr && cpuSel == 3'd0) |=> !(vmWe || palWe));                       // R2
  AST_PAL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    palWe |-> vmAddr >= 14'h3F00);                                         // R4
  AST_VRAM_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    vmWe |-> vmAddr < 14'h3F00);                                           // R4
  AST_DRAWN_MANGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vmWe && renderOn && scanLine < 9'd240) |-> vmWdata == vmAddr[7:0]);   // R5
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (vmRd && !addrWr) |=>
      vmAddr == 14'($past(vmAddr) + ($past(step32) ? 14'd32 : 14'd1)));    // R6
  AST_ATTR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    glitchWr |-> !attrWe);                                                 // R7
  AST_ATTR_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    glitchWr |=> attrAddr == (($past(attrAddr) + 8'd4) & 8'hFC));          // R7
endmodule

bind vdata_port vdp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .renderOn(renderOn), .scanLine(scanLine),
  .step32(step32), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuSel(cpuSel),
  .vmAddr(vmAddr), .vmRd(vmRd), .vmWe(vmWe), .vmWdata(vmWdata),
  .palWe(palWe), .attrAddr(attrAddr), .attrWe(attrWe)
);

// File: tb/vdata_port_bench.sv
module vdata_port_bench;
  localparam int CLK_P = 10;
  localparam int Q = CLK_P / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pixEn = 1'b1, renderOn = 1'b0, step32 = 1'b0, gray = 1'b0;
  logic [8:0] scanLine = '0;
  logic cpuRd = 1'b0, cpuWr = 1'b0;
  logic [2:0] cpuSel = '0;
  logic [7:0] cpuWdata = '0, cpuRdata, vmWdata, vmRdata, palWdata, palRdata, attrWdata;
  logic [13:0] vmAddr;
  logic [4:0] palAddr;
  logic [7:0] attrAddr;
  logic vmRd, vmWe, palWe, attrWe;

  always #(CLK_P/2) clk = ~clk;

  vdata_port u_vdata_port (
    .clk(clk), .rst_n(rst_n), .pixEn(pixEn), .renderOn(renderOn), .scanLine(scanLine),
    .step32(step32), .gray(gray), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuSel(cpuSel),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .vmAddr(vmAddr), .vmRd(vmRd),
    .vmWe(vmWe), .vmWdata(vmWdata), .vmRdata(vmRdata), .palAddr(palAddr),
    .palWe(palWe), .palWdata(palWdata), .palRdata(palRdata), .attrAddr(attrAddr),
    .attrWe(attrWe), .attrWdata(attrWdata)
  );

  // simple bench memories
  logic [7:0] vmem [1024];
  logic [7:0] palMem [32];
  logic [7:0] attrMem [256];

  function automatic logic [7:0] vPat(int a);  return 8'(a) ^ 8'hA5; endfunction
  function automatic logic [7:0] pPat(int a);  return 8'h31 + 8'(a); endfunction
  function automatic logic [7:0] aPat(int a);  return 8'(a) ^ 8'h3C; endfunction

  initial begin
    for (int i = 0; i < 1024; i++) vmem[i] = vPat(i);
    for (int i = 0; i < 32; i++)   palMem[i] = pPat(i);
    for (int i = 0; i < 256; i++)  attrMem[i] = aPat(i);
  end

  always @(posedge clk) begin
    if (vmWe)   vmem[vmAddr[9:0]] <= vmWdata;
    if (palWe)  palMem[palAddr]   <= palWdata;
    if (attrWe) attrMem[attrAddr] <= attrWdata;
  end
  assign vmRdata  = vmem[vmAddr[9:0]];
  assign palRdata = palMem[palAddr];

  // scoreboard
  typedef struct {
    int          due;
    logic [13:0] addr;
    logic [7:0]  data;
    logic        pal;
    string       tag;
  } item_t;
  item_t rdQ[$];
  item_t wrQ[$];
  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: samples a quarter period after each falling edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk); #(Q);
      cyc++;
      if (vmRd) begin
        if (rdQ.size() == 0) chk(1'b0, "R1", "unexpected refill at addr", int'(vmAddr), 0);
        else begin
          it = rdQ.pop_front();
          chk(cyc == it.due, it.tag, "refill cycle", cyc, it.due);
          chk(vmAddr == it.addr, it.tag, "refill addr", int'(vmAddr), int'(it.addr));
        end
      end
      if (vmWe || palWe) begin
        if (wrQ.size() == 0) chk(1'b0, "R2", "unexpected commit at addr", int'(vmAddr), 0);
        else begin
          it = wrQ.pop_front();
          chk(cyc == it.due, it.tag, "commit cycle", cyc, it.due);
          chk(vmAddr == it.addr, it.tag, "commit addr", int'(vmAddr), int'(it.addr));
          chk(palWe == it.pal, it.tag, "commit route palette", int'(palWe), int'(it.pal));
          chk((palWe ? palWdata : vmWdata) == it.data, it.tag, "commit data",
              int'(palWe ? palWdata : vmWdata), int'(it.data));
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpuWrite(logic [2:0] sel, logic [7:0] d);
    @(negedge clk);
    cpuWr = 1'b1; cpuSel = sel; cpuWdata = d;
    @(negedge clk);
    cpuWr = 1'b0; cpuSel = '0;
  endtask

  task automatic setAddr(logic [14:0] a);
    cpuWrite(3'd1, {1'b0, a[14:8]});
    cpuWrite(3'd2, a[7:0]);
  endtask

  // data-window write; push=0 means the access is expected to be superseded
  task automatic dataWrite(logic [7:0] d, bit push, logic [13:0] eAddr,
                           logic [7:0] eData, logic ePal, int extra, string tag);
    item_t it;
    @(negedge clk);
    if (push) begin
      it.due = cyc + 1 + 5 + extra; it.addr = eAddr; it.data = eData;
      it.pal = ePal; it.tag = tag;
      wrQ.push_back(it);
    end
    cpuWr = 1'b1; cpuSel = 3'd0; cpuWdata = d;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic dataRead(logic [7:0] exp, logic [13:0] fillAddr, string tag);
    item_t it;
    @(negedge clk);
    it.due = cyc + 1 + 5; it.addr = fillAddr; it.data = '0; it.pal = 1'b0; it.tag = tag;
    rdQ.push_back(it);
    cpuRd = 1'b1; cpuSel = 3'd0;
    #(Q);
    chk(cpuRdata == exp, tag, "read data", int'(cpuRdata), int'(exp));
    @(negedge clk);
    cpuRd = 1'b0;
  endtask

  initial begin
    item_t it;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R12: reset state
    chk(vmAddr == 14'h0, "R12", "reset addr", int'(vmAddr), 0);
    chk(attrAddr == 8'h0, "R12", "reset attr addr", int'(attrAddr), 0);
    chk(cpuRdata == 8'h0, "R12", "idle read data", int'(cpuRdata), 0);

    // R1/R12: first read returns reset buffer; second returns fetched byte
    setAddr(15'h0123);
    dataRead(8'h00, 14'h0123, "R12");
    idle(6);
    chk(vmAddr == 14'h0124, "R6", "advance by 1 after read", int'(vmAddr), 'h124);
    dataRead(vPat('h123), 14'h0124, "R1");
    idle(6);
    // R6: step of 32
    step32 = 1'b1;
    dataRead(vPat('h124), 14'h0125, "R6");
    idle(6);
    chk(vmAddr == 14'h0145, "R6", "advance by 32", int'(vmAddr), 'h145);
    step32 = 1'b0;

    // R2: deferred write
    setAddr(15'h0200);
    dataWrite(8'h77, 1'b1, 14'h0200, 8'h77, 1'b0, 0, "R2");
    idle(2);
    chk(vmem['h200] == vPat('h200), "R2", "memory before commit", int'(vmem['h200]), int'(vPat('h200)));
    chk(vmAddr == 14'h0200, "R6", "no advance at CPU write", int'(vmAddr), 'h200);
    idle(4);
    chk(vmem['h200] == 8'h77, "R2", "memory after commit", int'(vmem['h200]), 'h77);
    chk(vmAddr == 14'h0201, "R6", "advance after commit", int'(vmAddr), 'h201);

    // R9: restart with latch overwrite
    setAddr(15'h0210);
    dataWrite(8'h11, 1'b0, 14'h0, 8'h0, 1'b0, 0, "R9");
    dataWrite(8'h22, 1'b1, 14'h0210, 8'h22, 1'b0, 0, "R9");
    idle(6);
    chk(vmAddr == 14'h0211, "R9", "single advance", int'(vmAddr), 'h211);

    // R4: palette routing
    setAddr(15'h3F05);
    dataWrite(8'h2C, 1'b1, 14'h3F05, 8'h2C, 1'b1, 0, "R4");
    idle(6);
    chk(palMem[5] == 8'h2C, "R4", "palette content", int'(palMem[5]), 'h2C);
    chk(vmem['h305] == vPat('h305), "R4", "video memory untouched", int'(vmem['h305]), int'(vPat('h305)));

    // R8: palette read bypass and gray mask
    setAddr(15'h3F05);
    dataRead(8'h2C, 14'h3F05, "R8");
    idle(6);
    gray = 1'b1;
    dataRead(pPat(6) & 8'h30, 14'h3F06, "R8");
    idle(6);
    gray = 1'b0;

    // R3: bit 14 ignored
    setAddr(15'h7F07);
    chk(vmAddr == 14'h3F07, "R3", "masked bus addr", int'(vmAddr), 'h3F07);
    dataWrite(8'h15, 1'b1, 14'h3F07, 8'h15, 1'b1, 0, "R3");
    idle(6);
    chk(palMem[7] == 8'h15, "R3", "palette via masked addr", int'(palMem[7]), 'h15);

    // R5: rendering-time corruption and its line boundary
    renderOn = 1'b1; scanLine = 9'd100;
    setAddr(15'h0345);
    dataWrite(8'h99, 1'b1, 14'h0345, 8'h45, 1'b0, 0, "R5");
    idle(6);
    chk(vmem['h345] == 8'h45, "R5", "stored address byte", int'(vmem['h345]), 'h45);
    scanLine = 9'd240;
    setAddr(15'h0346);
    dataWrite(8'h99, 1'b1, 14'h0346, 8'h99, 1'b0, 0, "R5");
    idle(6);
    chk(vmem['h346] == 8'h99, "R5", "line 240 stores data", int'(vmem['h346]), 'h99);

    // R7: attribute port
    renderOn = 1'b0;
    cpuWrite(3'd3, 8'h10);
    cpuWrite(3'd4, 8'hAB);
    idle(1);
    chk(attrMem['h10] == 8'hAB, "R7", "attr stored", int'(attrMem['h10]), 'hAB);
    chk(attrAddr == 8'h11, "R7", "attr addr +1", int'(attrAddr), 'h11);
    renderOn = 1'b1; scanLine = 9'd50;
    cpuWrite(3'd3, 8'h13);
    cpuWrite(3'd4, 8'hCD);
    idle(1);
    chk(attrMem['h13] == aPat('h13), "R7", "attr unchanged in render", int'(attrMem['h13]), int'(aPat('h13)));
    chk(attrAddr == 8'h14, "R7", "attr glitch bump", int'(attrAddr), 'h14);
    scanLine = 9'd261;
    cpuWrite(3'd3, 8'h16);
    cpuWrite(3'd4, 8'hCD);
    idle(1);
    chk(attrMem['h16] == aPat('h16), "R7", "attr unchanged pre-line", int'(attrMem['h16]), int'(aPat('h16)));
    chk(attrAddr == 8'h18, "R7", "attr bump pre-line", int'(attrAddr), 'h18);
    scanLine = 9'd245;
    cpuWrite(3'd4, 8'hEE);
    idle(1);
    chk(attrMem['h18] == 8'hEE, "R7", "attr stored off-line", int'(attrMem['h18]), 'hEE);
    chk(attrAddr == 8'h19, "R7", "attr +1 off-line", int'(attrAddr), 'h19);
    renderOn = 1'b0; scanLine = 9'd0;

    // R11: pixel-step stall
    setAddr(15'h0220);
    dataWrite(8'h3C, 1'b1, 14'h0220, 8'h3C, 1'b0, 10, "R11");
    pixEn = 1'b0;
    idle(10);
    pixEn = 1'b1;
    idle(6);
    chk(vmem['h220] == 8'h3C, "R11", "stalled commit content", int'(vmem['h220]), 'h3C);

    // R10: read refill and write commit in the same cycle
    setAddr(15'h0230);
    @(negedge clk);
    it.due = cyc + 1 + 6; it.addr = 14'h0230; it.data = '0; it.pal = 1'b0; it.tag = "R10";
    rdQ.push_back(it);
    it.data = 8'h4D;
    wrQ.push_back(it);
    cpuRd = 1'b1; cpuSel = 3'd0;
    @(negedge clk);
    cpuRd = 1'b0; cpuWr = 1'b1; cpuWdata = 8'h4D; pixEn = 1'b0;
    @(negedge clk);
    cpuWr = 1'b0; pixEn = 1'b1;
    idle(7);
    chk(vmAddr == 14'h0231, "R10", "one advance", int'(vmAddr), 'h231);
    chk(vmem['h230] == 8'h4D, "R10", "write stored", int'(vmem['h230]), 'h4D);
    dataRead(vPat('h230), 14'h0231, "R10");
    idle(6);

    // R6: address load in the completion cycle wins
    setAddr(15'h0240);
    dataWrite(8'h01, 1'b1, 14'h0240, 8'h01, 1'b0, 0, "R6");
    idle(3);
    cpuWrite(3'd2, 8'h50);
    idle(2);
    chk(vmAddr == 14'h0250, "R6", "CPU load beats advance", int'(vmAddr), 'h250);

    idle(8);
    chk(rdQ.size() == 0, "R1", "refills outstanding", rdQ.size(), 0);
    chk(wrQ.size() == 0, "R2", "commits outstanding", wrQ.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule